// File: doc/BRIEF.md
# Priority-Resolved Multifunction Pin Selector

This block decides, for each of six shared pins, which on-chip signal drives the pad. Every pin has up to three choices in a fixed order: a high-priority function signal, a low-priority function signal, and GPIO as the last resort. Each choice is enabled by an OR of one or more functions. Each function is an AND of field comparisons over several 32-bit control words and one strap word. Some comparisons require a field to be clear rather than set, and one compares a two-bit mode field against a value.

The control words are written and read over a simple register port. The strap word takes its value from input pins at the first clock edge after reset is released. Software can read it but cannot write it, so a function that depends only on strap bits stays on whatever software writes. Selection is purely combinational from the current register contents. Each pin reports a two-bit selection code, and its pad output and output enable are steered from the source that matches.

Top module: `prio_pinmux`

## Requirements
- R1: After reset every writable control word reads zero, and every pin whose functions do not depend on strap bits reports code 2'b00 (GPIO).
- R2: The selection code per pin is 2'b10 for high priority, 2'b01 for low priority and 2'b00 for GPIO, held in pin_sel[2p+1:2p]. pad_out[p] and pad_oe[p] equal the high, low or GPIO source bit that the code names.
- R3: A pin reports low priority only when its high-priority signal is not requested. It falls back to GPIO only when neither is requested.
- R4: A write to offset 0x70 (strap) leaves the strap word unchanged, and a read of 0x70 returns the captured strap value.
- R5: The strap word is captured from strap_pins at the first rising clock edge after rst_n rises. Later changes on strap_pins change neither its readback nor any selection.
- R6: Control words at offsets 0x3C, 0x80, 0x84, 0x90 and 0xA4 read back the last value written. An unmapped offset reads zero. The selections follow a write on the cycle after the write edge.
- R7: Pin 0 is high priority exactly when 0x80 bit 0 is 1. It has no low-priority signal.
- R8: Pin 1 is high priority when 0x90 bit 22 is 1. Otherwise it is low priority when 0x80 bit 4 is 1.
- R9: Pin 2 is high priority when 0x3C bit 3, 0x80 bit 15 are both 1 and 0x90 bit 31 is 0. It is low priority when those two bits are 1 and 0x90 bit 31 is 1.
- R10: Pin 3 is high priority when the video mode field 0x90[5:4] is nonzero (01, 10 and 11 are the 18, 24 and 30-bit modes) and 0x84 bit 17 is 1. Otherwise it is low priority when 0x84 bit 17 is 1.
- R11: Pin 4 is high priority when 0x90[5:4] equals 11 and 0x84 bit 22 is 1. Otherwise it is low priority when 0x84 bit 22 is 1.
- R12: Pin 5 is high priority when 0x80 bit 25 is 1. Otherwise it is low priority when 0xA4 bit 12 is 1 or strap bit 19 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_pins | input | 32 | Strap levels, captured once after reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational readback of the word at reg_addr |
| hi_src_out | input | 6 | High-priority signal data, one bit per pin |
| hi_src_oe | input | 6 | High-priority signal output enable per pin |
| lo_src_out | input | 6 | Low-priority signal data per pin |
| lo_src_oe | input | 6 | Low-priority signal output enable per pin |
| gpio_out | input | 6 | GPIO data per pin |
| gpio_oe | input | 6 | GPIO output enable per pin |
| pin_sel | output | 12 | Two-bit selection code per pin |
| pad_out | output | 6 | Steered pad data |
| pad_oe | output | 6 | Steered pad output enable |

## Verification
The selection path has no state of its own, so a wrong control bit or a wrong strap capture shows in pin_sel and on the pad one cycle after the write that caused it. The sweep walks every combination of the twelve control bits that any expression reads, plus unrelated noise bits, and compares all six codes and pads after every setting. A strap word that is lost or overwritten shows on pin 5 and on readback of 0x70 within a cycle. Both strap polarities are covered, each with its own reset.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    localparam int REG_W    = 32;
    localparam int NUM_PINS = 6;

    // Register byte offsets (software visible)
    localparam logic [7:0] OFF_MISC   = 8'h3C;
    localparam logic [7:0] OFF_STRAP  = 8'h70;
    localparam logic [7:0] OFF_FSEL_A = 8'h80;
    localparam logic [7:0] OFF_FSEL_B = 8'h84;
    localparam logic [7:0] OFF_FSEL_C = 8'h90;
    localparam logic [7:0] OFF_FSEL_D = 8'hA4;

    typedef enum logic [1:0] {
        SEL_GPIO = 2'b00,
        SEL_LOW  = 2'b01,
        SEL_HIGH = 2'b10
    } pin_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] misc;
        logic [REG_W-1:0] fsel_a;
        logic [REG_W-1:0] fsel_b;
        logic [REG_W-1:0] fsel_c;
        logic [REG_W-1:0] fsel_d;
        logic [REG_W-1:0] strap;
    } ctl_regs_t;

    typedef struct packed {
        ctl_regs_t ctl;
        logic      captured;
    } reg_state_t;

    // One comparison term: field [lsb +: width] of word equals val
    function automatic logic field_is(input logic [REG_W-1:0] word,
                                      input int lsb, input int width,
                                      input int unsigned val);
        logic [REG_W-1:0] shifted;
        logic [REG_W-1:0] mask;
        shifted = word >> lsb;
        mask    = (REG_W'(1) << width) - REG_W'(1);
        return (shifted & mask) == (REG_W'(val) & mask);
    endfunction

endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  strap_pins,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output ctl_regs_t         ctl_o
);

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.captured) begin
            st_d.ctl.strap = strap_pins;
            st_d.captured  = 1'b1;
        end
        if (reg_wr) begin
            case (reg_addr)
                ADDR_W'(OFF_MISC):   st_d.ctl.misc   = reg_wdata;
                ADDR_W'(OFF_FSEL_A): st_d.ctl.fsel_a = reg_wdata;
                ADDR_W'(OFF_FSEL_B): st_d.ctl.fsel_b = reg_wdata;
                ADDR_W'(OFF_FSEL_C): st_d.ctl.fsel_c = reg_wdata;
                ADDR_W'(OFF_FSEL_D): st_d.ctl.fsel_d = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr)
            ADDR_W'(OFF_MISC):   reg_rdata = st_q.ctl.misc;
            ADDR_W'(OFF_STRAP):  reg_rdata = st_q.ctl.strap;
            ADDR_W'(OFF_FSEL_A): reg_rdata = st_q.ctl.fsel_a;
            ADDR_W'(OFF_FSEL_B): reg_rdata = st_q.ctl.fsel_b;
            ADDR_W'(OFF_FSEL_C): reg_rdata = st_q.ctl.fsel_c;
            ADDR_W'(OFF_FSEL_D): reg_rdata = st_q.ctl.fsel_d;
            default:             reg_rdata = '0;
        endcase
    end

    assign ctl_o = st_q.ctl;

    // R4: software cannot alter the strap word
    a_r4_strap_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.captured && reg_wr && reg_addr == ADDR_W'(OFF_STRAP)) |=> $stable(st_q.ctl.strap));

    // R5: once captured, the strap word holds
    a_r5_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.captured |=> $stable(st_q.ctl.strap));

    // R6: a write to a control word lands on the next edge
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFF_FSEL_C)) |=> (ctl_o.fsel_c == $past(reg_wdata)));

endmodule

// File: rtl/pinmux_expr.sv
module pinmux_expr
    import pinmux_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  ctl_regs_t           ctl_i,
    output logic [NUM_PINS-1:0] hi_req,
    output logic [NUM_PINS-1:0] lo_req
);

    // Function terms, each an AND of field comparisons
    logic fn_link, fn_i2c_clk, fn_timer, fn_rst_base, fn_rst, fn_cs;
    logic fn_vid_any, fn_vid_30, fn_de_pin, fn_txd_pin;
    logic fn_carrier, fn_sio_sw, fn_sio_strap;

    always_comb begin
        fn_link      = field_is(ctl_i.fsel_a, 0, 1, 1);
        fn_i2c_clk   = field_is(ctl_i.fsel_c, 22, 1, 1);
        fn_timer     = field_is(ctl_i.fsel_a, 4, 1, 1);
        fn_rst_base  = field_is(ctl_i.misc, 3, 1, 1) && field_is(ctl_i.fsel_a, 15, 1, 1);
        fn_rst       = fn_rst_base && field_is(ctl_i.fsel_c, 31, 1, 0);
        fn_cs        = fn_rst_base && field_is(ctl_i.fsel_c, 31, 1, 1);
        fn_de_pin    = field_is(ctl_i.fsel_b, 17, 1, 1);
        fn_txd_pin   = field_is(ctl_i.fsel_b, 22, 1, 1);
        // Video data-enable: any of the three video modes
        fn_vid_any   = (field_is(ctl_i.fsel_c, 4, 2, 1) && fn_de_pin)
                    || (field_is(ctl_i.fsel_c, 4, 2, 2) && fn_de_pin)
                    || (field_is(ctl_i.fsel_c, 4, 2, 3) && fn_de_pin);
        fn_vid_30    = field_is(ctl_i.fsel_c, 4, 2, 3) && fn_txd_pin;
        fn_carrier   = field_is(ctl_i.fsel_a, 25, 1, 1);
        fn_sio_sw    = field_is(ctl_i.fsel_d, 12, 1, 1);
        fn_sio_strap = field_is(ctl_i.strap, 19, 1, 0);
    end

    always_comb begin
        hi_req = '0;
        lo_req = '0;
        hi_req[0] = fn_link;
        hi_req[1] = fn_i2c_clk;
        lo_req[1] = fn_timer;
        hi_req[2] = fn_rst;
        lo_req[2] = fn_cs;
        hi_req[3] = fn_vid_any;
        lo_req[3] = fn_de_pin;
        hi_req[4] = fn_vid_30;
        lo_req[4] = fn_txd_pin;
        hi_req[5] = fn_carrier;
        lo_req[5] = fn_sio_sw || fn_sio_strap;
    end

    // Bits of the control words that no expression reads
    logic unused_ctl;
    assign unused_ctl = ^ctl_i;

    // R9: reset and chip-select requests on pin 2 never coincide
    a_r9_rst_cs_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_req[2] && lo_req[2]));

    // R11: video data high request implies its low enable is also set
    a_r11_vid_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
        hi_req[4] |-> lo_req[4]);

endmodule

// File: rtl/pinmux_resolve.sv
module pinmux_resolve
    import pinmux_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   hi_req,
    input  logic [NUM_PINS-1:0]   lo_req,
    input  logic [NUM_PINS-1:0]   hi_src_out,
    input  logic [NUM_PINS-1:0]   hi_src_oe,
    input  logic [NUM_PINS-1:0]   lo_src_out,
    input  logic [NUM_PINS-1:0]   lo_src_oe,
    input  logic [NUM_PINS-1:0]   gpio_out,
    input  logic [NUM_PINS-1:0]   gpio_oe,
    output logic [2*NUM_PINS-1:0] sel_o,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        pin_sel_e sel;

        always_comb begin
            if (hi_req[g])      sel = SEL_HIGH;
            else if (lo_req[g]) sel = SEL_LOW;
            else                sel = SEL_GPIO;
        end

        always_comb begin
            case (sel)
                SEL_HIGH: begin pad_out[g] = hi_src_out[g]; pad_oe[g] = hi_src_oe[g]; end
                SEL_LOW:  begin pad_out[g] = lo_src_out[g]; pad_oe[g] = lo_src_oe[g]; end
                default:  begin pad_out[g] = gpio_out[g];   pad_oe[g] = gpio_oe[g];   end
            endcase
        end

        assign sel_o[2*g +: 2] = sel;

        // R3: low priority only while high is not requested
        a_r3_low_blocked: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_o[2*g +: 2] == SEL_LOW) |-> !hi_req[g]);

        // R3: GPIO only when no function is requested
        a_r3_gpio_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_o[2*g +: 2] == SEL_GPIO) |-> (!hi_req[g] && !lo_req[g]));

        // R2: code is never the unused value
        a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
            sel_o[2*g +: 2] != 2'b11);
    end

endmodule

// File: rtl/prio_pinmux.sv
module prio_pinmux
    import pinmux_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_W-1:0]      strap_pins,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic [NUM_PINS-1:0]   hi_src_out,
    input  logic [NUM_PINS-1:0]   hi_src_oe,
    input  logic [NUM_PINS-1:0]   lo_src_out,
    input  logic [NUM_PINS-1:0]   lo_src_oe,
    input  logic [NUM_PINS-1:0]   gpio_out,
    input  logic [NUM_PINS-1:0]   gpio_oe,
    output logic [2*NUM_PINS-1:0] pin_sel,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe
);

    ctl_regs_t           ctl;
    logic [NUM_PINS-1:0] hi_req;
    logic [NUM_PINS-1:0] lo_req;

    pinmux_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_pins (strap_pins),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ctl_o      (ctl)
    );

    pinmux_expr u_expr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_i  (ctl),
        .hi_req (hi_req),
        .lo_req (lo_req)
    );

    pinmux_resolve u_resolve (
        .clk        (clk),
        .rst_n      (rst_n),
        .hi_req     (hi_req),
        .lo_req     (lo_req),
        .hi_src_out (hi_src_out),
        .hi_src_oe  (hi_src_oe),
        .lo_src_out (lo_src_out),
        .lo_src_oe  (lo_src_oe),
        .gpio_out   (gpio_out),
        .gpio_oe    (gpio_oe),
        .sel_o      (pin_sel),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

endmodule

// File: tb/prio_pinmux_tb.sv
`timescale 1ns/100ps
module prio_pinmux_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] strap_pins = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  hi_src_out = '0, hi_src_oe = '0, lo_src_out = '0, lo_src_oe = '0;
    logic [5:0]  gpio_out = '0, gpio_oe = '0;
    logic [11:0] pin_sel;
    logic [5:0]  pad_out, pad_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prio_pinmux dut_i (
        .clk(clk), .rst_n(rst_n), .strap_pins(strap_pins),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hi_src_out(hi_src_out), .hi_src_oe(hi_src_oe),
        .lo_src_out(lo_src_out), .lo_src_oe(lo_src_oe),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .pin_sel(pin_sel), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic string pin_tag(int p);
        case (p)
            0: return "R7";
            1: return "R8";
            2: return "R9";
            3: return "R10";
            4: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(string tag, logic [7:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic do_reset(logic [31:0] s);
        rst_n = 1'b0;
        strap_pins = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Expected code for pin p from the control bits (b) and strap bit 19
    function automatic logic [1:0] exp_sel(int p, logic [11:0] b, logic s19);
        logic hi, lo;
        logic [1:0] vm;
        vm = b[8:7];
        case (p)
            0: begin hi = b[1]; lo = 1'b0; end
            1: begin hi = b[9]; lo = b[2]; end
            2: begin hi = b[0] & b[3] & ~b[10]; lo = b[0] & b[3] & b[10]; end
            3: begin hi = (vm != 2'b00) & b[5]; lo = b[5]; end
            4: begin hi = (vm == 2'b11) & b[6]; lo = b[6]; end
            default: begin hi = b[4]; lo = b[11] | ~s19; end
        endcase
        return hi ? 2'b10 : (lo ? 2'b01 : 2'b00);
    endfunction

    task automatic apply_bits(logic [11:0] b, bit noise);
        logic [31:0] m, a, bb, c, d;
        m  = (32'(b[0]) << 3);
        a  = (32'(b[1]) << 0) | (32'(b[2]) << 4) | (32'(b[3]) << 15) | (32'(b[4]) << 25);
        bb = (32'(b[5]) << 17) | (32'(b[6]) << 22);
        c  = (32'(b[8:7]) << 4) | (32'(b[9]) << 22) | (32'(b[10]) << 31);
        d  = (32'(b[11]) << 12);
        if (noise) begin
            m |= 32'h0F0F_0004; a |= 32'h0000_0A02; bb |= 32'h0001_0003;
            c |= 32'h0000_0008; d |= 32'h0000_2800;
        end
        wr(8'h3C, m); wr(8'h80, a); wr(8'h84, bb); wr(8'h90, c); wr(8'hA4, d);
        rd_check("R6 readback 0x90", 8'h90, c);
    endtask

    task automatic check_pins(logic [11:0] b, logic s19);
        logic [1:0] es;
        logic eo, ee;
        hi_src_out = b[5:0];  hi_src_oe = b[11:6];
        lo_src_out = ~b[5:0]; lo_src_oe = b[11:6] ^ 6'h15;
        gpio_out = b[5:0] ^ 6'h2A; gpio_oe = ~b[11:6];
        #1;
        for (int p = 0; p < 6; p++) begin
            es = exp_sel(p, b, s19);
            check({"R3/", pin_tag(p), " sel"}, 32'(pin_sel[2*p +: 2]), 32'(es));
            eo = (es == 2'b10) ? hi_src_out[p] : (es == 2'b01) ? lo_src_out[p] : gpio_out[p];
            ee = (es == 2'b10) ? hi_src_oe[p]  : (es == 2'b01) ? lo_src_oe[p]  : gpio_oe[p];
            check("R2 pad steering", {30'd0, pad_out[p], pad_oe[p]}, {30'd0, eo, ee});
        end
    endtask

    initial begin
        // Phase 1: strap bit 19 high
        do_reset(32'hFFFF_FFFF);
        // R1: reset state
        check("R1 sel after reset", 32'(pin_sel), 32'd0);
        rd_check("R1 reset 0x80", 8'h80, 32'd0);
        rd_check("R1 reset 0x90", 8'h90, 32'd0);
        rd_check("R5 strap captured", 8'h70, 32'hFFFF_FFFF);
        // R6: unmapped offset
        rd_check("R6 unmapped read", 8'h44, 32'd0);
        // R5: later strap pin changes ignored
        strap_pins = 32'h0000_0000;
        repeat (3) @(negedge clk);
        rd_check("R5 strap held", 8'h70, 32'hFFFF_FFFF);
        check("R5 pin5 unaffected", 32'(pin_sel[11:10]), 32'd0);
        // R4: write to strap ignored
        wr(8'h70, 32'h0000_0000);
        rd_check("R4 strap write ignored", 8'h70, 32'hFFFF_FFFF);
        check("R4 pin5 after strap write", 32'(pin_sel[11:10]), 32'd0);
        // Sweep of every relevant control bit combination
        for (int c = 0; c < 4096; c++) begin
            apply_bits(12'(c), c[0] ^ c[5]);
            check_pins(12'(c), 1'b1);
        end
        // Phase 2: strap bit 19 low forces pin 5 low-priority signal
        do_reset(32'h0007_0000);
        check("R12 strap forces low", 32'(pin_sel[11:10]), 32'd1);
        check("R1 other pins GPIO", 32'(pin_sel[9:0]), 32'd0);
        wr(8'hA4, 32'd0);
        check("R12 software cannot clear", 32'(pin_sel[11:10]), 32'd1);
        wr(8'h80, 32'h0200_0000);
        check("R12 high overrides", 32'(pin_sel[11:10]), 32'd2);
        wr(8'h80, 32'h0);
        check("R12 back to low", 32'(pin_sel[11:10]), 32'd1);
        for (int c = 0; c < 4096; c += 37) begin
            apply_bits(12'(c), 1'b0);
            check_pins(12'(c), 1'b0);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule